// File: doc/BRIEF.md
# LSD Radix Sorter

This block orders a run of unsigned 64-bit keys that sit in one of two external key memories. It performs one stable counting pass per radix digit, starting with the least significant digit. Each pass has four steps. First it zeroes an internal tally table. Next it reads every key and counts how often each digit value occurs. It then rewrites the tally table in place as an exclusive running sum. Finally it reads the keys again and writes each one to the slot held in the table entry for its digit, raising that entry by one after every write. Source and destination memories trade places after each pass.

A controller loads keys into memory A from address 0 upward, sets `key_count` and pulses `start`. When `done` pulses, `result_in_b` tells it which memory holds the sorted keys. With the default 13-bit digit there are five passes: the last one covers bits [63:52], and the result lands in memory B. Both key memories are simple synchronous RAMs. Read data appears one clock after the address.

Top module: `lsd_radix_sorter`

## Requirements
- R1: After reset, `done` and `result_in_b` are 0 and neither memory's write enable is high.
- R2: When `done` pulses, words 0 to `key_count`-1 of the result memory hold the input keys in ascending unsigned order.
- R3: Each pass writes every key exactly once, into the destination memory only, at an address below `key_count`. A whole sort therefore makes (pass count × `key_count`) writes, and the two write enables are never high together.
- R4: The pass count is ceil(KEY_W/DIGIT_W). Pass p uses key bits starting at p×DIGIT_W, and the last digit may be narrower. Even passes read A and write B, odd passes do the reverse. `result_in_b` is 1 exactly when the pass count is odd: 5 passes at default parameters, 13 passes with 5-bit digits.
- R5: Each pass takes 2·2^DIGIT_W + 2·`key_count` + 2 cycles. Counting the edge that samples `start` as edge 0, `done` is high just after edge (pass count) × (2·2^DIGIT_W + 2·`key_count` + 2).
- R6: A `key_count` of 0 completes with a `done` pulse and no memory writes. A `key_count` of 1 completes with the single key at address 0 of the result memory.
- R7: `done` is high for exactly one cycle. A `start` that arrives while a sort is running is ignored: it changes neither the completion time nor the result, and produces no second `done`.
- R8: Each pass is stable. Keys that share their upper digits but differ in lower digits stay in correct relative order through the later passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a sort when idle |
| key_count | input | AW+1 | Number of keys, 0 to 2^AW |
| done | output | 1 | One-cycle completion pulse |
| result_in_b | output | 1 | 1: sorted keys are in memory B; 0: in memory A |
| a_rd_addr | output | AW | Memory A read address |
| a_rd_data | input | KEY_W | Memory A read data, one cycle after the address |
| a_wr_en | output | 1 | Memory A write enable |
| a_wr_addr | output | AW | Memory A write address |
| a_wr_data | output | KEY_W | Memory A write data |
| b_rd_addr | output | AW | Memory B read address |
| b_rd_data | input | KEY_W | Memory B read data, one cycle after the address |
| b_wr_en | output | 1 | Memory B write enable |
| b_wr_addr | output | AW | Memory B write address |
| b_wr_data | output | KEY_W | Memory B write data |

## Verification
The sorter is run on several key sets, each aimed at a different fault:
- Mixed extremes: all ones, zero, a lone top bit and a key set only in its last, narrow digit. These catch errors in digit extraction and in the narrow final digit.
- Heavy duplicates: these expose bad slot-pointer increments.
- Already-sorted input: this reveals ordering damage by the passes themselves.
- Keys sharing high digits and differing only in low digits: these fail unless every pass is stable.

Key counts of zero, one and two, together with a `start` pulse during a busy sort, cover the edges of the handshake. The completion time and the total write count are checked on every run.

// File: rtl/lsd_radix_sorter.sv
module lsd_radix_sorter #(
  parameter int KEY_W   = 64,
  parameter int DIGIT_W = 13,
  parameter int AW      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW:0]      key_count,
  output logic             done,
  output logic             result_in_b,
  output logic [AW-1:0]    a_rd_addr,
  input  logic [KEY_W-1:0] a_rd_data,
  output logic             a_wr_en,
  output logic [AW-1:0]    a_wr_addr,
  output logic [KEY_W-1:0] a_wr_data,
  output logic [AW-1:0]    b_rd_addr,
  input  logic [KEY_W-1:0] b_rd_data,
  output logic             b_wr_en,
  output logic [AW-1:0]    b_wr_addr,
  output logic [KEY_W-1:0] b_wr_data
);
  localparam int NP  = (KEY_W + DIGIT_W - 1) / DIGIT_W;
  localparam int ENT = 1 << DIGIT_W;
  localparam int CW  = AW + 1;
  localparam int PW  = $clog2(NP + 1);
  localparam logic [CW-1:0]      ONE  = 1;
  localparam logic [DIGIT_W-1:0] TONE = 1;

  typedef enum logic [2:0] {IDLE, CLR, CNT, PFX, SCT} st_t;

  st_t                state;
  logic [PW-1:0]      pass;
  logic [CW-1:0]      idx, nreg, sum;
  logic [DIGIT_W-1:0] tix;
  logic               rd_v;
  logic [CW-1:0]      tally [ENT];

  wire              scan   = (state == CNT) || (state == SCT);
  wire              issue  = scan && (idx < nreg);
  wire [KEY_W-1:0]  rd_key = pass[0] ? b_rd_data : a_rd_data;
  wire [DIGIT_W-1:0] dig   = DIGIT_W'(rd_key >> (pass * DIGIT_W));
  wire              wr_now = (state == SCT) && rd_v;
  wire [AW-1:0]     wr_addr = tally[dig][AW-1:0];

  assign a_rd_addr = idx[AW-1:0];
  assign b_rd_addr = idx[AW-1:0];
  assign a_wr_en   = wr_now && pass[0];
  assign b_wr_en   = wr_now && !pass[0];
  assign a_wr_addr = wr_addr;
  assign b_wr_addr = wr_addr;
  assign a_wr_data = rd_key;
  assign b_wr_data = rd_key;

  always_ff @(posedge clk) begin
    if (state == CLR)
      tally[tix] <= '0;
    else if (state == PFX)
      tally[tix] <= sum;
    else if (scan && rd_v)
      tally[dig] <= tally[dig] + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= IDLE;
      pass        <= '0;
      idx         <= '0;
      nreg        <= '0;
      sum         <= '0;
      tix         <= '0;
      rd_v        <= 1'b0;
      done        <= 1'b0;
      result_in_b <= 1'b0;
    end else begin
      done <= 1'b0;
      rd_v <= issue;
      case (state)
        IDLE: if (start) begin
          nreg  <= key_count;
          pass  <= '0;
          tix   <= '0;
          state <= CLR;
        end
        CLR: begin
          tix <= tix + TONE;
          if (tix == '1) begin
            idx   <= '0;
            state <= CNT;
          end
        end
        CNT, SCT: begin
          if (issue)
            idx <= idx + ONE;
          else if (state == CNT) begin
            tix   <= '0;
            sum   <= '0;
            state <= PFX;
          end else if (pass == PW'(NP - 1)) begin
            done        <= 1'b1;
            result_in_b <= ~pass[0];
            state       <= IDLE;
          end else begin
            pass  <= pass + PW'(1);
            tix   <= '0;
            state <= CLR;
          end
        end
        PFX: begin
          sum <= sum + tally[tix];
          tix <= tix + TONE;
          if (tix == '1) begin
            idx   <= '0;
            state <= SCT;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE) |-> !(a_wr_en || b_wr_en));

  a_r3_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_wr_en && b_wr_en));

  a_r3_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr_en || b_wr_en) |-> ({1'b0, wr_addr} < nreg));

  a_r4_result_parity: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result_in_b == (NP % 2 == 1)));

  a_r6_zero_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state != IDLE && nreg == '0) |-> !(a_wr_en || b_wr_en));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state != IDLE && start) |=> (state != IDLE || $past(state) == SCT));
endmodule

// File: tb/tb_lsd_radix_sorter.sv
module tb_lsd_radix_sorter;
  localparam int KW = 64, DW = 5, AW = 4;
  localparam int NP = (KW + DW - 1) / DW;
  localparam int ENT = 1 << DW;
  localparam int NV = 5;

  localparam logic [63:0] VK [NV][8] = '{
    '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
      64'h1, 64'hF000_0000_0000_0000, 64'h1F, 64'h0123_4567_89AB_CDEF},
    '{64'h5, 64'h3, 64'h5, 64'h3, 64'hA, 64'h5, 64'hA, 64'h3},
    '{64'h10, 64'h20, 64'h300, 64'h4000, 64'h5_0000, 64'h60_0000, 64'h700_0000, 64'h0},
    '{64'hABCD_0000_0000_0007, 64'hABCD_0000_0000_0003, 64'hABCD_0000_0000_0005,
      64'hABCD_0000_0000_0001, 64'h1BCD_0000_0000_0009, 64'hABCD_0000_0000_0002,
      64'h1BCD_0000_0000_0004, 64'hABCD_0000_0000_0000},
    '{64'hDEAD_BEEF_0000_0001, 64'h0000_0000_DEAD_BEEF, 64'h0, 64'h0,
      64'h0, 64'h0, 64'h0, 64'h0}
  };
  localparam int VN [NV] = '{8, 8, 7, 8, 2};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW:0] key_count = '0;
  logic done, result_in_b;
  logic [AW-1:0] a_rd_addr, a_wr_addr, b_rd_addr, b_wr_addr;
  logic [KW-1:0] a_rd_data, a_wr_data, b_rd_data, b_wr_data;
  logic a_wr_en, b_wr_en;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [KW-1:0] ld_data = '0;
  logic [KW-1:0] mema [1 << AW];
  logic [KW-1:0] memb [1 << AW];
  int wcount = 0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  lsd_radix_sorter #(.KEY_W(KW), .DIGIT_W(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .key_count(key_count),
    .done(done), .result_in_b(result_in_b),
    .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data), .a_wr_en(a_wr_en),
    .a_wr_addr(a_wr_addr), .a_wr_data(a_wr_data),
    .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data), .b_wr_en(b_wr_en),
    .b_wr_addr(b_wr_addr), .b_wr_data(b_wr_data));

  always_ff @(posedge clk) begin
    if (ld_en) mema[ld_addr] <= ld_data;
    else if (a_wr_en) mema[a_wr_addr] <= a_wr_data;
    if (b_wr_en) memb[b_wr_addr] <= b_wr_data;
    a_rd_data <= mema[a_rd_addr];
    b_rd_data <= memb[b_rd_addr];
    if (a_wr_en || b_wr_en) wcount <= wcount + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_sort(input int n, input logic [63:0] keys [8], input int poke);
    logic [63:0] exp [8];
    logic [63:0] t, got;
    int cycles, w0, lat;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(i); ld_data = keys[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    for (int i = 0; i < 8; i++) exp[i] = keys[i];
    for (int i = 0; i < n; i++)
      for (int j = 0; j + 1 < n - i; j++)
        if (exp[j] > exp[j+1]) begin t = exp[j]; exp[j] = exp[j+1]; exp[j+1] = t; end
    w0 = wcount;
    key_count = (AW+1)'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cycles = 0;
    while (!done && cycles < 5000) begin
      @(negedge clk);
      cycles++;
      start = (cycles == poke);
    end
    start = 1'b0;
    lat = NP * (2 * ENT + 2 * n + 2);
    check(cycles == lat, "R5", "done latency", 64'(cycles), 64'(lat));
    check(result_in_b == (NP % 2 == 1), "R4", "result buffer", 64'(result_in_b), 64'(NP % 2));
    check(wcount - w0 == NP * n, "R3", "write count", 64'(wcount - w0), 64'(NP * n));
    for (int i = 0; i < n; i++) begin
      got = result_in_b ? memb[i] : mema[i];
      check(got == exp[i], "R2 R8", "sorted word", got, exp[i]);
    end
    @(negedge clk);
    check(done == 1'b0, "R7", "done width", 64'(done), 64'(0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] kv [8];
    int late;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && result_in_b == 1'b0 && !a_wr_en && !b_wr_en, "R1",
          "reset outputs", {61'b0, done, result_in_b, a_wr_en | b_wr_en}, 64'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!a_wr_en && !b_wr_en, "R1", "idle writes", 64'(a_wr_en | b_wr_en), 64'(0));

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 8; i++) kv[i] = VK[v][i];
      run_sort(VN[v], kv, -1);
    end

    for (int i = 0; i < 8; i++) kv[i] = 64'h0;
    run_sort(0, kv, -1);
    kv[0] = 64'h0000_5555_0000_AAAA;
    run_sort(1, kv, -1);
    check(memb[0] == 64'h0000_5555_0000_AAAA, "R6", "single key in B[0]",
          memb[0], 64'h0000_5555_0000_AAAA);

    for (int i = 0; i < 8; i++) kv[i] = VK[0][7 - i];
    run_sort(8, kv, 100);
    late = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) late++;
    end
    check(late == 0, "R7", "extra done after busy start", 64'(late), 64'(0));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule